// File: doc/BRIEF.md
# Dual Timer/Event Counter

The block holds two independent 16-bit up-counters. Each counter is kept as a high byte and a low byte, and software can load either byte on its own. A divide-by-12 prescaler inside the block produces a one-clock machine-cycle strobe. In timer mode a running counter advances by one on every strobe. In event mode the counter counts falling edges of its own external pin. The pin passes through a two-flop synchronizer and is then sampled once per machine cycle.

An event is recognised only when one sample is high and the next sample is low. The count rises on the strobe after the one that saw the edge, so the fastest pin the block can count toggles once per machine cycle. A counter that wraps from all ones to zero raises its overflow flag. An interrupt acknowledge from the interrupt logic clears the flag, and a direct software write can set it or clear it.

Top module: `dual_event_timer`

## Requirements
- R1: After a synchronous reset, both counters read 0x0000 and both overflow flags read 0.
- R2: The internal strobe fires once every 12 clocks. In timer mode (`event_mode` bit = 0) with `run_en` high and no byte write, the counter rises by exactly 1 over every 12-clock window.
- R3: In event mode (`event_mode` bit = 1) the count rises by one for each falling edge of the pin. The edge is seen as a high sample followed by a low sample, taken once per strobe after a two-flop synchronizer. A pin held steady at either level adds nothing.
- R4: An event detected at one strobe increments the count at the next strobe, and only then. The strobe that uses a detected event also drops it.
- R5: A pin that toggles once per machine cycle (24-clock period) gives exactly one count per 24 clocks. That is the highest event rate the block can count.
- R6: With `run_en` low the count holds. Pin sampling goes on, but an event that reaches its increment strobe while `run_en` is low is lost.
- R7: `wr_lo`/`wr_hi` load `wr_data` into the low/high byte of that channel at the next clock. A write in a cycle blocks any increment in that cycle, and a byte that is not written keeps its value.
- R8: An increment from 0xFFFF gives 0x0000 and sets that channel's overflow flag. Other increments leave the flag alone.
- R9: `ovf_ack` clears the flag. `ovf_we` loads `ovf_wval` into the flag. The priority, highest first, is software write, then the rollover set, then the acknowledge.
- R10: Nothing driven on one channel's inputs changes the other channel's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 2 | External event pin per channel (asynchronous) |
| run_en | input | 2 | Run enable per channel |
| event_mode | input | 2 | Per channel: 0 = timer, 1 = event counter |
| wr_lo | input | 2 | Load low byte of the channel from wr_data |
| wr_hi | input | 2 | Load high byte of the channel from wr_data |
| wr_data | input | 8 | Shared byte write data |
| ovf_ack | input | 2 | Hardware acknowledge, clears the flag |
| ovf_we | input | 2 | Software flag write enable |
| ovf_wval | input | 2 | Software flag write value |
| cnt_lo | output | 16 | Low bytes, channel 0 in bits 7:0 |
| cnt_hi | output | 16 | High bytes, channel 0 in bits 7:0 |
| ovf | output | 2 | Overflow flags |

## Verification
The assertions assume the synchronous control inputs (`run_en`, `event_mode`, the writes, the acknowledges and `ovf_we`) change only between clock edges. They place no rule on the pins, which may change at any time. The stimulus drives every input on the falling clock edge. Pins are toggled at random but with a low rate of change, so both sampled levels and isolated edges occur. Byte writes and flag writes are kept rare, so that long counting stretches reach rollover after a near-full value has been preloaded.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_EVENT = 1'b1
  } cnt_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cycle_prescaler.sv
module cycle_prescaler #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      pre_q  <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      tick_o <= (pre_q == LAST);
    end
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/edge_sampler.sv
module edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pin_i,
  output logic pend_o
);
  logic sync1_q, sync2_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      last_q  <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (tick_i) begin
        last_q <= sync2_q;
        pend_o <= last_q & ~sync2_q;
      end
    end
  end

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pend_o));
  // R3
  pend_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_o) |-> $past(last_q));
endmodule

// File: rtl/count_unit.sv
module count_unit #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic          ack_i,
  input  logic          ovf_we_i,
  input  logic          ovf_wval_i,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          ovf_o
);
  localparam int unsigned CW = 2 * BW;

  logic [CW-1:0] cnt_q;
  logic          any_wr, step, roll;

  assign any_wr = wr_lo_i | wr_hi_i;
  assign step   = inc_i & ~any_wr;
  assign roll   = step & (&cnt_q);
  assign lo_o   = cnt_q[BW-1:0];
  assign hi_o   = cnt_q[CW-1:BW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr_lo_i) cnt_q[BW-1:0]  <= wr_data_i;
      if (wr_hi_i) cnt_q[CW-1:BW] <= wr_data_i;
      if (step)    cnt_q          <= cnt_q + 1'b1;
      if (ovf_we_i)   ovf_o <= ovf_wval_i;
      else if (roll)  ovf_o <= 1'b1;
      else if (ack_i) ovf_o <= 1'b0;
    end
  end

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !wr_lo_i && !wr_hi_i) |=> ({hi_o, lo_o} == $past({hi_o, lo_o}) + 1'b1));
  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !wr_lo_i && !wr_hi_i) |=> $stable({hi_o, lo_o}));
  // R7
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo_i |=> (lo_o == $past(wr_data_i)));
  // R7
  hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo_i && !wr_hi_i) |=> (hi_o == $past(hi_o)));
  // R8
  rollover_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !wr_lo_i && !wr_hi_i && hi_o == '1 && lo_o == '1 && !ovf_we_i) |=> ovf_o);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !ovf_we_i && !(inc_i && !any_wr && hi_o == '1 && lo_o == '1)) |=> !ovf_o);
  // R9
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_we_i |=> (ovf_o == $past(ovf_wval_i)));
endmodule

// File: rtl/dual_event_timer.sv
module dual_event_timer #(
  parameter int unsigned NCH = 2,
  parameter int unsigned BW  = tcnt_pkg::BYTE_W,
  parameter int unsigned DIV = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  ext_pin,
  input  logic [NCH-1:0]  run_en,
  input  logic [NCH-1:0]  event_mode,
  input  logic [NCH-1:0]  wr_lo,
  input  logic [NCH-1:0]  wr_hi,
  input  logic [BW-1:0]   wr_data,
  input  logic [NCH-1:0]  ovf_ack,
  input  logic [NCH-1:0]  ovf_we,
  input  logic [NCH-1:0]  ovf_wval,
  output logic [NCH*BW-1:0] cnt_lo,
  output logic [NCH*BW-1:0] cnt_hi,
  output logic [NCH-1:0]  ovf
);
  import tcnt_pkg::*;

  logic tick;

  cycle_prescaler #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic      pend, inc;
    cnt_mode_e mode;

    assign mode = cnt_mode_e'(event_mode[ch]);

    edge_sampler u_es (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .pin_i  (ext_pin[ch]),
      .pend_o (pend)
    );

    always_comb begin
      inc = 1'b0;
      if (tick && run_en[ch]) begin
        case (mode)
          MODE_TIMER: inc = 1'b1;
          MODE_EVENT: inc = pend;
          default:    inc = 1'b0;
        endcase
      end
    end

    count_unit #(.BW(BW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .inc_i      (inc),
      .wr_lo_i    (wr_lo[ch]),
      .wr_hi_i    (wr_hi[ch]),
      .wr_data_i  (wr_data),
      .ack_i      (ovf_ack[ch]),
      .ovf_we_i   (ovf_we[ch]),
      .ovf_wval_i (ovf_wval[ch]),
      .lo_o       (cnt_lo[ch*BW +: BW]),
      .hi_o       (cnt_hi[ch*BW +: BW]),
      .ovf_o      (ovf[ch])
    );

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_en[ch] && !wr_lo[ch] && !wr_hi[ch]) |=>
        $stable({cnt_hi[ch*BW +: BW], cnt_lo[ch*BW +: BW]}));
  end
endmodule

// File: tb/tb_dual_event_timer.sv
module tb_dual_event_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_pin = '0, run_en = '0, event_mode = '0;
  logic [1:0]  wr_lo = '0, wr_hi = '0, ovf_ack = '0, ovf_we = '0, ovf_wval = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cnt_lo, cnt_hi;
  logic [1:0]  ovf;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_event_timer dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .run_en(run_en),
    .event_mode(event_mode), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .ovf_ack(ovf_ack), .ovf_we(ovf_we), .ovf_wval(ovf_wval),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf(ovf)
  );

  // Reference model built from the requirements
  logic [3:0]  m_pre;
  logic        m_tick;
  logic [1:0]  m_s1, m_s2, m_last, m_pend, m_ovf;
  logic [15:0] m_cnt [2];

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= 0; m_tick <= 0; m_s1 <= 0; m_s2 <= 0; m_last <= 0; m_pend <= 0; m_ovf <= 0;
      m_cnt[0] <= 0; m_cnt[1] <= 0;
    end else begin
      m_pre  <= (m_pre == 11) ? 4'd0 : m_pre + 4'd1;
      m_tick <= (m_pre == 11);
      m_s1 <= ext_pin;
      m_s2 <= m_s1;
      if (m_tick) begin
        m_last <= m_s2;
        m_pend <= m_last & ~m_s2;
      end
      for (int c = 0; c < 2; c++) begin
        logic inc, wr, roll;
        logic [15:0] nv;
        inc  = m_tick && run_en[c] && (event_mode[c] ? m_pend[c] : 1'b1);
        wr   = wr_lo[c] || wr_hi[c];
        roll = inc && !wr && (m_cnt[c] == 16'hFFFF);
        nv   = m_cnt[c];
        if (wr_lo[c]) nv[7:0]  = wr_data;
        if (wr_hi[c]) nv[15:8] = wr_data;
        if (inc && !wr) nv = m_cnt[c] + 16'd1;
        m_cnt[c] <= nv;
        if (ovf_we[c])     m_ovf[c] <= ovf_wval[c];
        else if (roll)     m_ovf[c] <= 1'b1;
        else if (ovf_ack[c]) m_ovf[c] <= 1'b0;
      end
    end
  end

  function automatic logic [15:0] cnt_of(int c);
    return {cnt_hi[c*8 +: 8], cnt_lo[c*8 +: 8]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    void'($urandom(32'h1234_5678));
    clocks(4);
    rst = 1'b0;
    clocks(1);
    check("R1 cnt0", cnt_of(0), 0);
    check("R1 cnt1", cnt_of(1), 0);
    check("R1 ovf", ovf, 0);

    // R2: timer mode, +1 per 12 clocks
    run_en = 2'b11; event_mode = 2'b00;
    clocks(30);
    for (int i = 0; i < 4; i++) begin
      a = cnt_of(0);
      clocks(12);
      check("R2 timer step", cnt_of(0), a + 16'd1);
    end

    // R6: freeze
    run_en = 2'b00;
    a = cnt_of(0); b = cnt_of(1);
    clocks(60);
    check("R6 freeze ch0", cnt_of(0), a);
    check("R6 freeze ch1", cnt_of(1), b);

    // R10: write ch0 only, ch1 untouched
    wr_lo = 2'b01; wr_data = 8'hA5; clocks(1); wr_lo = 0;
    check("R10 ch0 lo", cnt_of(0), {a[15:8], 8'hA5});
    check("R10 ch1 same", cnt_of(1), b);

    // R7: write holds low byte while timer runs
    run_en = 2'b01; wr_lo = 2'b01; wr_data = 8'h55;
    clocks(40);
    check("R7 write wins lo", cnt_of(0), {a[15:8], 8'h55});
    wr_lo = 0;

    // R3: steady pin, event mode
    event_mode = 2'b11; run_en = 2'b11; ext_pin = 2'b11;
    clocks(50);
    a = cnt_of(0);
    clocks(60);
    check("R3 steady high", cnt_of(0), a);
    ext_pin = 2'b00;
    clocks(60);
    check("R3 one fall", cnt_of(0), a + 16'd1);
    clocks(60);
    check("R3 steady low", cnt_of(0), a + 16'd1);

    // R5: toggle every 12 clocks -> one count per 24 clocks
    for (int i = 0; i < 10; i++) begin ext_pin = ~ext_pin; clocks(12); end
    a = cnt_of(0);
    for (int i = 0; i < 20; i++) begin ext_pin = ~ext_pin; clocks(12); end
    check("R5 max rate", cnt_of(0), a + 16'd10);

    // R8 / R9: rollover and acknowledge
    event_mode = 2'b00; run_en = 2'b01;
    wr_lo = 2'b01; wr_hi = 2'b01; wr_data = 8'hFF; clocks(1);
    wr_lo = 0; wr_hi = 0;
    check("R8 no flag yet", ovf[0], 0);
    clocks(13);
    check("R8 wrap count", cnt_of(0), 0);
    check("R8 flag set", ovf[0], 1);
    ovf_ack = 2'b01; clocks(1); ovf_ack = 0;
    check("R9 ack clears", ovf[0], 0);
    ovf_we = 2'b10; ovf_wval = 2'b10; clocks(1); ovf_we = 0;
    check("R9 sw set", ovf, 2'b10);
    ovf_we = 2'b10; ovf_wval = 2'b00; ovf_ack = 2'b10; clocks(1);
    ovf_we = 0; ovf_ack = 0;
    check("R9 sw clear", ovf[1], 0);

    // Random phase against the model (R4 timing, priorities, all modes)
    for (int i = 0; i < 6000; i++) begin
      check("R4 model cnt0", cnt_of(0), m_cnt[0]);
      check("R4 model cnt1", cnt_of(1), m_cnt[1]);
      check("R9 model flags", ovf, m_ovf);
      run_en = ($urandom % 16 == 0) ? 2'($urandom) : run_en | 2'b11 & 2'($urandom % 4 != 0 ? 3 : $urandom);
      if ($urandom % 200 == 0) event_mode = 2'($urandom);
      if ($urandom % 5 == 0) ext_pin = ext_pin ^ 2'($urandom);
      wr_lo = ($urandom % 60 == 0) ? 2'($urandom) : 2'b00;
      wr_hi = ($urandom % 60 == 0) ? 2'($urandom) : 2'b00;
      wr_data = ($urandom % 2) ? 8'hFF : 8'($urandom);
      ovf_ack = ($urandom % 20 == 0) ? 2'($urandom) : 2'b00;
      ovf_we = ($urandom % 40 == 0) ? 2'($urandom) : 2'b00;
      ovf_wval = 2'($urandom);
      clocks(1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule